// File: doc/BRIEF.md
# Banked Memory Region Attribute Unit

This block turns an access address into the memory attributes the cache and bus logic need: whether the location may be cached, which allocation hints apply, write-back or write-through, transient, shareable, and whether it is normal memory or device memory. It keeps two independent banks of programmable regions, one for the secure state and one for the non-secure state. Each region has a base, an inclusive limit, an attribute set and its own enable bit.

A lookup gives an address, the kind of access (instruction fetch or data), the current security state, the security attribute of the address and a privilege flag. The bank to consult depends on the kind of access. A fetch consults the bank named by the address's own security attribute. A data access consults the bank of the current security state. When the chosen bank is switched off, a fixed built-in address map supplies the attributes. When the bank is on, a matching region supplies them. A privileged access that misses every region may instead fall back to the built-in map. Any other miss, and any address claimed by two or more regions, is reported as a fault.

Two address windows configured as tightly coupled memory are never reported as cacheable. For data accesses, shareable memory is also never reported as cacheable. Each result comes out one clock after its request.

Top module: `mem_attr_resolver`

## Requirements
- R1: After reset, `rs_valid` is 0, both banks are disabled and every region is disabled, so lookups take their attributes from the built-in map with `rs_hit`=0 and `rs_fault`=0.
- R2: A lookup presented with `lk_valid`=1 at a rising edge produces `rs_valid`=1 and its result after that edge. A cycle with `lk_valid`=0 produces `rs_valid`=0 after the next edge.
- R3: With `cfg_we`=1, `cfg_ns` selects the bank (0 secure, 1 non-secure) and `cfg_op` selects the operation. Code 0 writes the base of region `cfg_idx`, code 1 writes its limit, code 2 writes its attributes (`cfg_wdata[6:0]`) and its enable bit (`cfg_wdata[7]`), and code 3 writes the bank controls (`cfg_wdata[0]` bank enable, `cfg_wdata[1]` background enable). A write takes effect for lookups in the following cycle.
- R4: A stored base has its low 5 address bits cleared. A stored limit has its low 5 address bits set. A region covers base through limit inclusive, so its extent is a multiple of 32 bytes.
- R5: A fetch (`lk_fetch`=1) uses the bank given by `lk_addr_ns`. A data access (`lk_fetch`=0) uses the bank given by `lk_cur_ns`.
- R6: Attribute bit positions are: bit 0 cacheable, bit 1 read-allocate, bit 2 write-allocate, bit 3 write-back (0 means write-through), bit 4 transient, bit 5 shareable, bit 6 device (0 means normal).
- R7: When the selected bank is disabled, the attributes come from the built-in map, indexed by address bits [31:29]:
  - 0: 0x03
  - 1: 0x0F
  - 2: 0x40
  - 3: 0x0F
  - 4: 0x03
  - 5 and 6: 0x60
  - 7: 0x40

  The result has `rs_hit`=0 and `rs_fault`=0.
- R8: When the selected bank is enabled and exactly one enabled region covers the address, that region's attributes are reported with `rs_hit`=1 and `rs_region` holding its index.
- R9: A region whose enable bit is 0 never matches.
- R10: An address covered by two or more enabled regions of the selected bank gives `rs_fault`=1, `rs_hit`=0 and all attribute bits 0.
- R11: When the selected bank is enabled and no region matches, a privileged access (`lk_priv`=1) with background enable set takes the built-in map with `rs_fault`=0. Every other such miss gives `rs_fault`=1 with all attribute bits 0.
- R12: Addresses inside the instruction TCM window (default 0x0000_0000 to 0x0003_FFFF) or the data TCM window (default 0x2000_0000 to 0x2001_FFFF) are reported with cacheable, read-allocate and write-allocate all 0, whatever the source of the attributes.
- R13: For a data access whose resolved attributes are shareable, cacheable is reported as 0. A fetch reports cacheable unchanged regardless of shareability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ns | input | 1 | Bank targeted by the write (1 = non-secure) |
| cfg_op | input | 2 | Write operation code |
| cfg_idx | input | 3 | Region index for region writes |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_cur_ns | input | 1 | Current security state (1 = non-secure) |
| lk_addr_ns | input | 1 | Security attribute of the address (1 = non-secure) |
| lk_priv | input | 1 | Privileged access |
| rs_valid | output | 1 | Result valid |
| rs_attr | output | 7 | Resolved attributes |
| rs_hit | output | 1 | A single region matched |
| rs_region | output | 3 | Index of the matching region |
| rs_fault | output | 1 | Miss without fallback, or overlapping regions |

## Verification
The bench builds the block with its defaults: eight regions per bank, 32-bit addresses, a 32-byte granule, and TCM windows at the bottom of the code area and the bottom of the SRAM area. Random region bases and limits are kept inside narrow address windows, several of which lie inside a TCM window. This makes overlapping regions, granule-edge hits and TCM overrides of programmed attributes occur often. Directed cases cover the base and limit rounding, the bank choice by access kind, and the privileged fallback.

// File: rtl/mattr_pkg.sv
package mattr_pkg;
  localparam int ATTR_W   = 7;
  localparam int MAP_BITS = 3;

  localparam logic [1:0] OP_BASE  = 2'd0;
  localparam logic [1:0] OP_LIMIT = 2'd1;
  localparam logic [1:0] OP_ATTR  = 2'd2;
  localparam logic [1:0] OP_CTRL  = 2'd3;

  typedef struct packed {
    logic device;
    logic shareable;
    logic transient;
    logic write_back;
    logic wr_alloc;
    logic rd_alloc;
    logic cacheable;
  } mattr_t;
endpackage

// File: rtl/mattr_rst_sync.sv
module mattr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/mattr_region_bank.sv
module mattr_region_bank
  import mattr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NREG      = 8,
  parameter int GRAN_BITS = 5,
  parameter int IDX_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [1:0]                       wr_op,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]                wr_data,
  output logic [NREG-1:0][ADDR_W-1:0]      base_o,
  output logic [NREG-1:0][ADDR_W-1:0]      limit_o,
  output mattr_t [NREG-1:0]                attr_o,
  output logic [NREG-1:0]                  ren_o,
  output logic                             bank_en_o,
  output logic                             bg_en_o
);
  localparam int HI_W = ADDR_W - GRAN_BITS;

  logic ctrl_ld;
  logic bank_en_q, bg_en_q;

  assign ctrl_ld = wr_en && (wr_op == OP_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en_q <= 1'b0;
      bg_en_q   <= 1'b0;
    end else if (ctrl_ld) begin
      bank_en_q <= wr_data[0];
      bg_en_q   <= wr_data[1];
    end
  end

  assign bank_en_o = bank_en_q;
  assign bg_en_o   = bg_en_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic            sel;
    logic            ld_base, ld_limit, ld_attr;
    logic [HI_W-1:0] base_q, limit_q;
    mattr_t          attr_q;
    logic            ren_q;

    assign sel      = wr_en && (wr_idx == IDX_W'(r));
    assign ld_base  = sel && (wr_op == OP_BASE);
    assign ld_limit = sel && (wr_op == OP_LIMIT);
    assign ld_attr  = sel && (wr_op == OP_ATTR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        attr_q  <= '0;
        ren_q   <= 1'b0;
      end else begin
        if (ld_base)  base_q  <= wr_data[ADDR_W-1:GRAN_BITS];
        if (ld_limit) limit_q <= wr_data[ADDR_W-1:GRAN_BITS];
        if (ld_attr) begin
          attr_q <= wr_data[ATTR_W-1:0];
          ren_q  <= wr_data[ATTR_W];
        end
      end
    end

    assign base_o[r]  = {base_q,  {GRAN_BITS{1'b0}}};
    assign limit_o[r] = {limit_q, {GRAN_BITS{1'b1}}};
    assign attr_o[r]  = attr_q;
    assign ren_o[r]   = ren_q;
  end
endmodule

// File: rtl/mattr_region_match.sv
module mattr_region_match #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NREG-1:0][ADDR_W-1:0]  base,
  input  logic [NREG-1:0][ADDR_W-1:0]  limit,
  input  logic [NREG-1:0]              ren,
  output logic                         any_o,
  output logic                         multi_o,
  output logic [IDX_W-1:0]             idx_o
);
  localparam int CNT_W = IDX_W + 1;

  logic [NREG-1:0] hit_vec;
  logic [CNT_W-1:0] cnt;

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    assign hit_vec[r] = ren[r] && (addr >= base[r]) && (addr <= limit[r]);
  end

  always_comb begin
    cnt   = '0;
    idx_o = '0;
    for (int r = 0; r < NREG; r++) begin
      cnt = cnt + CNT_W'(hit_vec[r]);
    end
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit_vec[r]) idx_o = IDX_W'(r);
    end
  end

  assign any_o   = |hit_vec;
  assign multi_o = cnt > CNT_W'(1);
endmodule

// File: rtl/mattr_default_map.sv
module mattr_default_map
  import mattr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output mattr_t            attr_o
);
  logic [MAP_BITS-1:0] area;

  assign area = addr[ADDR_W-1 -: MAP_BITS];

  always_comb begin
    attr_o = '0;
    unique case (area)
      3'd0, 3'd4: begin
        attr_o.cacheable = 1'b1;
        attr_o.rd_alloc  = 1'b1;
      end
      3'd1, 3'd3: begin
        attr_o.cacheable  = 1'b1;
        attr_o.rd_alloc   = 1'b1;
        attr_o.wr_alloc   = 1'b1;
        attr_o.write_back = 1'b1;
      end
      3'd5, 3'd6: begin
        attr_o.device    = 1'b1;
        attr_o.shareable = 1'b1;
      end
      default: attr_o.device = 1'b1;
    endcase
  end
endmodule

// File: rtl/mem_attr_resolver.sv
module mem_attr_resolver
  import mattr_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          NUM_REGIONS = 8,
  parameter int          GRAN_BITS   = 5,
  parameter logic [31:0] ITCM_BASE   = 32'h0000_0000,
  parameter logic [31:0] ITCM_LIMIT  = 32'h0003_FFFF,
  parameter logic [31:0] DTCM_BASE   = 32'h2000_0000,
  parameter logic [31:0] DTCM_LIMIT  = 32'h2001_FFFF,
  localparam int         IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ns,
  input  logic [1:0]        cfg_op,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_fetch,
  input  logic              lk_cur_ns,
  input  logic              lk_addr_ns,
  input  logic              lk_priv,
  output logic              rs_valid,
  output logic [ATTR_W-1:0] rs_attr,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_region,
  output logic              rs_fault
);
  localparam int NBANK = 2;

  logic rst_q_n;

  mattr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] bk_base  [NBANK];
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] bk_limit [NBANK];
  mattr_t [NUM_REGIONS-1:0]           bk_attr  [NBANK];
  logic [NUM_REGIONS-1:0]             bk_ren   [NBANK];
  logic [NBANK-1:0]                   bk_en, bk_bg, bk_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bk_we[b] = cfg_we && (cfg_ns == (b == 1));
    mattr_region_bank #(
      .ADDR_W(ADDR_W), .NREG(NUM_REGIONS), .GRAN_BITS(GRAN_BITS), .IDX_W(IDX_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_q_n), .wr_en(bk_we[b]), .wr_op(cfg_op),
      .wr_idx(cfg_idx), .wr_data(cfg_wdata),
      .base_o(bk_base[b]), .limit_o(bk_limit[b]), .attr_o(bk_attr[b]),
      .ren_o(bk_ren[b]), .bank_en_o(bk_en[b]), .bg_en_o(bk_bg[b])
    );
  end

  // bank choice: fetches follow the address, data follows the current state
  logic sel_ns, sel_en, sel_bg;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] sel_base, sel_limit;
  mattr_t [NUM_REGIONS-1:0]           sel_attr;
  logic [NUM_REGIONS-1:0]             sel_ren;

  assign sel_ns    = lk_fetch ? lk_addr_ns : lk_cur_ns;
  assign sel_en    = bk_en[sel_ns];
  assign sel_bg    = bk_bg[sel_ns];
  assign sel_base  = bk_base[sel_ns];
  assign sel_limit = bk_limit[sel_ns];
  assign sel_attr  = bk_attr[sel_ns];
  assign sel_ren   = bk_ren[sel_ns];

  logic             mm_any, mm_multi;
  logic [IDX_W-1:0] mm_idx;

  mattr_region_match #(.ADDR_W(ADDR_W), .NREG(NUM_REGIONS), .IDX_W(IDX_W)) u_match (
    .addr(lk_addr), .base(sel_base), .limit(sel_limit), .ren(sel_ren),
    .any_o(mm_any), .multi_o(mm_multi), .idx_o(mm_idx)
  );

  mattr_t dflt_attr;

  mattr_default_map #(.ADDR_W(ADDR_W)) u_dmap (.addr(lk_addr), .attr_o(dflt_attr));

  logic in_tcm;
  assign in_tcm = ((lk_addr >= ADDR_W'(ITCM_BASE)) && (lk_addr <= ADDR_W'(ITCM_LIMIT))) ||
                  ((lk_addr >= ADDR_W'(DTCM_BASE)) && (lk_addr <= ADDR_W'(DTCM_LIMIT)));

  mattr_t           res_attr;
  logic             res_hit, res_fault;
  logic [IDX_W-1:0] res_idx;

  always_comb begin
    res_attr  = '0;
    res_hit   = 1'b0;
    res_fault = 1'b0;
    res_idx   = '0;
    if (!sel_en) begin
      res_attr = dflt_attr;
    end else if (mm_multi) begin
      res_fault = 1'b1;
    end else if (mm_any) begin
      res_attr = sel_attr[mm_idx];
      res_hit  = 1'b1;
      res_idx  = mm_idx;
    end else if (sel_bg && lk_priv) begin
      res_attr = dflt_attr;
    end else begin
      res_fault = 1'b1;
    end
    if (in_tcm) begin
      res_attr.cacheable = 1'b0;
      res_attr.rd_alloc  = 1'b0;
      res_attr.wr_alloc  = 1'b0;
    end
    if (!lk_fetch && res_attr.shareable) res_attr.cacheable = 1'b0;
  end

  // result register stage
  logic             out_valid_q, out_valid_d;
  mattr_t           out_attr_q;
  logic             out_hit_q, out_fault_q;
  logic [IDX_W-1:0] out_idx_q;

  always_comb out_valid_d = lk_valid;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid_q <= 1'b0;
      out_attr_q  <= '0;
      out_hit_q   <= 1'b0;
      out_fault_q <= 1'b0;
      out_idx_q   <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      if (lk_valid) begin
        out_attr_q  <= res_attr;
        out_hit_q   <= res_hit;
        out_fault_q <= res_fault;
        out_idx_q   <= res_idx;
      end
    end
  end

  assign rs_valid  = out_valid_q;
  assign rs_attr   = out_attr_q;
  assign rs_hit    = out_hit_q;
  assign rs_fault  = out_fault_q;
  assign rs_region = out_idx_q;
endmodule

// File: rtl/mattr_chk.sv
module mattr_chk #(
  parameter int          ADDR_W     = 32,
  parameter int          ATTR_W     = 7,
  parameter logic [31:0] ITCM_BASE  = 32'h0000_0000,
  parameter logic [31:0] ITCM_LIMIT = 32'h0003_FFFF,
  parameter logic [31:0] DTCM_BASE  = 32'h2000_0000,
  parameter logic [31:0] DTCM_LIMIT = 32'h2001_FFFF
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              lk_valid,
  input logic              lk_fetch,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              sel_en,
  input logic              mm_multi,
  input logic              rs_valid,
  input logic [ATTR_W-1:0] rs_attr,
  input logic              rs_hit,
  input logic              rs_fault
);
  logic addr_tcm;
  assign addr_tcm = ((lk_addr >= ADDR_W'(ITCM_BASE)) && (lk_addr <= ADDR_W'(ITCM_LIMIT))) ||
                    ((lk_addr >= ADDR_W'(DTCM_BASE)) && (lk_addr <= ADDR_W'(DTCM_LIMIT)));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    lk_valid |=> rs_valid);

  // R2
  no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !lk_valid |=> !rs_valid);

  // R8
  hit_fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rs_valid |-> !(rs_hit && rs_fault));

  // R11
  fault_clears_attr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rs_valid && rs_fault) |-> (rs_attr == '0));

  // R7
  off_bank_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lk_valid && !sel_en) |=> (!rs_fault && !rs_hit));

  // R10
  overlap_faults_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lk_valid && sel_en && mm_multi) |=> rs_fault);

  // R12
  tcm_uncached_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lk_valid && addr_tcm) |=> (rs_attr[2:0] == 3'b000));

  // R13
  shared_data_uncached_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lk_valid && !lk_fetch) |=> !(rs_attr[5] && rs_attr[0]));
endmodule

bind mem_attr_resolver mattr_chk #(
  .ADDR_W(ADDR_W), .ATTR_W(mattr_pkg::ATTR_W),
  .ITCM_BASE(ITCM_BASE), .ITCM_LIMIT(ITCM_LIMIT),
  .DTCM_BASE(DTCM_BASE), .DTCM_LIMIT(DTCM_LIMIT)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .lk_valid(lk_valid), .lk_fetch(lk_fetch),
  .lk_addr(lk_addr), .sel_en(sel_en), .mm_multi(mm_multi),
  .rs_valid(rs_valid), .rs_attr(rs_attr), .rs_hit(rs_hit), .rs_fault(rs_fault)
);

// File: tb/mem_attr_resolver_tb_top.sv
module mem_attr_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_ns = 1'b0;
  logic [1:0]  cfg_op = 2'd0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        lk_valid = 1'b0, lk_fetch = 1'b0, lk_cur_ns = 1'b0, lk_addr_ns = 1'b0, lk_priv = 1'b0;
  logic [31:0] lk_addr = 32'd0;
  logic        rs_valid, rs_hit, rs_fault;
  logic [6:0]  rs_attr;
  logic [2:0]  rs_region;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mem_attr_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ns(cfg_ns), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_fetch(lk_fetch), .lk_cur_ns(lk_cur_ns), .lk_addr_ns(lk_addr_ns), .lk_priv(lk_priv),
    .rs_valid(rs_valid), .rs_attr(rs_attr), .rs_hit(rs_hit), .rs_region(rs_region),
    .rs_fault(rs_fault)
  );

  // shadow of programmed state
  logic [31:0] m_base  [2][8];
  logic [31:0] m_limit [2][8];
  logic [6:0]  m_attr  [2][8];
  bit          m_ren   [2][8];
  bit          m_en    [2];
  bit          m_bg    [2];

  function automatic logic [6:0] dmap(input logic [31:0] a);
    case (a[31:29])
      3'd0, 3'd4: return 7'h03;
      3'd1, 3'd3: return 7'h0F;
      3'd5, 3'd6: return 7'h60;
      default:    return 7'h40;
    endcase
  endfunction

  // expected {valid, fault, hit, region, attr}
  function automatic logic [12:0] model(input logic [31:0] a, input bit f, input bit cns,
                                        input bit ans, input bit pv);
    int bk = f ? int'(ans) : int'(cns);
    int cnt = 0;
    int first = 0;
    logic [6:0] at = 7'h00;
    bit h = 0, flt = 0;
    for (int r = 7; r >= 0; r--) begin
      if (m_ren[bk][r] && a >= m_base[bk][r] && a <= m_limit[bk][r]) begin
        cnt++;
        first = r;
      end
    end
    if (!m_en[bk]) at = dmap(a);
    else if (cnt > 1) flt = 1;
    else if (cnt == 1) begin at = m_attr[bk][first]; h = 1; end
    else if (m_bg[bk] && pv) at = dmap(a);
    else flt = 1;
    if ((a <= 32'h0003_FFFF) || (a >= 32'h2000_0000 && a <= 32'h2001_FFFF)) at[2:0] = 3'b000;
    if (!f && at[5]) at[0] = 1'b0;
    return {1'b1, flt, h, (h ? 3'(first) : 3'd0), at};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit ns, input logic [1:0] op, input logic [2:0] idx,
                           input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ns = ns; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
    case (op)
      2'd0: m_base[ns][idx]  = d & ~32'h1F;
      2'd1: m_limit[ns][idx] = d | 32'h1F;
      2'd2: begin m_attr[ns][idx] = d[6:0]; m_ren[ns][idx] = d[7]; end
      default: begin m_en[ns] = d[0]; m_bg[ns] = d[1]; end
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input bit f, input bit cns, input bit ans,
                        input bit pv, input string req);
    logic [12:0] exp, act;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_fetch = f; lk_cur_ns = cns; lk_addr_ns = ans; lk_priv = pv;
    exp = model(a, f, cns, ans, pv);
    @(negedge clk);
    lk_valid = 1'b0;
    act = {rs_valid, rs_fault, rs_hit, (rs_hit ? rs_region : 3'd0), rs_attr};
    chk(act == exp, req, $sformatf("lookup %h", a), 32'(act), 32'(exp));
  endtask

  function automatic logic [31:0] rnd_addr();
    logic [2:0] areas [6] = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd5, 3'd4};
    return {areas[$urandom_range(0, 5)], 16'h0000, 13'($urandom)};
  endfunction

  initial begin
    int sd;
    sd = $urandom(32'h5EED_0708);
    for (int b = 0; b < 2; b++) begin
      m_en[b] = 0; m_bg[b] = 0;
      for (int r = 0; r < 8; r++) begin
        m_base[b][r] = 32'h0; m_limit[b][r] = 32'h1F; m_attr[b][r] = 7'h0; m_ren[b][r] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rs_valid == 1'b0, "R1", "rs_valid after reset", 32'(rs_valid), 32'd0);
    lookup(32'h2004_0000, 0, 0, 0, 1, "R1 R7 sram default");
    lookup(32'h6000_0100, 1, 0, 0, 0, "R7 ext ram default");
    lookup(32'hA000_0000, 0, 1, 1, 0, "R7 device default");
    @(negedge clk);
    chk(rs_valid == 1'b0, "R2", "rs_valid idle", 32'(rs_valid), 32'd0);

    // granule rounding on secure region 0
    cfg_write(0, 2'd0, 3'd0, 32'h2004_0013);
    cfg_write(0, 2'd1, 3'd0, 32'h2004_0020);
    cfg_write(0, 2'd2, 3'd0, 32'h0000_009B);
    cfg_write(0, 2'd3, 3'd0, 32'h1);
    lookup(32'h2004_0000, 0, 0, 0, 1, "R3 R4 R6 R8 base rounded down");
    lookup(32'h2004_003F, 0, 0, 0, 1, "R4 limit inclusive");
    lookup(32'h2004_0040, 0, 0, 0, 1, "R4 R11 past limit faults");
    lookup(32'h2003_FFFF, 0, 0, 0, 1, "R4 R11 below base faults");
    cfg_write(0, 2'd3, 3'd0, 32'h3);
    lookup(32'h2004_0040, 0, 0, 0, 1, "R11 privileged fallback");
    lookup(32'h2004_0040, 0, 0, 0, 0, "R11 unprivileged faults");

    // bank choice
    lookup(32'h2004_0000, 0, 1, 0, 1, "R5 data follows current state");
    lookup(32'h2004_0000, 1, 1, 0, 1, "R5 fetch follows address");
    lookup(32'h2004_0000, 1, 0, 1, 1, "R5 fetch non-secure address");

    // region enable and overlap
    cfg_write(0, 2'd0, 3'd1, 32'h2004_0000);
    cfg_write(0, 2'd1, 3'd1, 32'h2004_00FF);
    cfg_write(0, 2'd2, 3'd1, 32'h0000_0003);
    lookup(32'h2004_0010, 0, 0, 0, 1, "R9 disabled region ignored");
    cfg_write(0, 2'd2, 3'd1, 32'h0000_0083);
    lookup(32'h2004_0010, 0, 0, 0, 1, "R10 overlap faults");
    lookup(32'h2004_0080, 0, 0, 0, 1, "R8 second region alone");
    cfg_write(0, 2'd2, 3'd1, 32'h0000_0003);

    // TCM override
    cfg_write(0, 2'd0, 3'd2, 32'h2000_0100);
    cfg_write(0, 2'd1, 3'd2, 32'h2000_01FF);
    cfg_write(0, 2'd2, 3'd2, 32'h0000_008F);
    lookup(32'h2000_0100, 0, 0, 0, 1, "R12 data tcm region");
    lookup(32'h0000_1000, 0, 1, 1, 1, "R12 instruction tcm default");

    // shareable
    cfg_write(0, 2'd0, 3'd3, 32'h3000_0000);
    cfg_write(0, 2'd1, 3'd3, 32'h3000_0FFF);
    cfg_write(0, 2'd2, 3'd3, 32'h0000_00A1);
    lookup(32'h3000_0800, 0, 0, 0, 1, "R13 data shareable");
    lookup(32'h3000_0800, 1, 1, 0, 1, "R13 fetch shareable");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] op = 2'($urandom);
        logic [31:0] d;
        case (op)
          2'd0, 2'd1: d = rnd_addr();
          2'd2:       d = 32'($urandom & 32'hFF);
          default:    d = 32'($urandom & 32'h3);
        endcase
        cfg_write(1'($urandom), op, 3'($urandom), d);
      end else begin
        lookup(rnd_addr(), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               "R3 R5 R8 R10 R11 R12 R13 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule